// File: doc/BRIEF.md
# Weighted Token Bus Arbiter

This block decides which of several DMA requesters may drive one shared bus master port next. Each requester has a request line, a priority level and a 4-bit weight. The arbiter hands out one burst at a time and keeps that grant until the burst-done input says the burst is over. Requesters are arranged in pairs: index 2k is the transmit side of pair k and index 2k+1 is its receive side. Each side is arbitrated on its own, with its own weight and its own early-refill disable bit.

Priority is compared first. Only requesters sitting at the highest requesting level are considered. In weighted mode, such a requester is granted only while it still holds tokens, and every granted burst spends one token. Token budgets are reloaded from the weights whenever a programmable cycle count runs out. They are also reloaded early when the top level has run dry and early refill is allowed there. Over time, bandwidth therefore follows the weights. When the global weighted enable is cleared, tokens play no part and only priority and round-robin decide.

Top module: `wtok_arbiter`

## Requirements
- R1: While reset is asserted and just after it, `gnt_o` is zero. Every requester starts with one token and the period counter starts at zero. The round-robin pointer starts so that the first tie goes to index 0.
- R2: At most one bit of `gnt_o` is high. A new grant goes only to a requester whose request was high in the cycle before the grant appears.
- R3: A grant stays unchanged until `done_i` is high at a clock edge. At that edge the next grant is chosen, so saturated bursts run back to back.
- R4: A larger `prio_i` field (levels 0 to 5, 3 bits per requester, requester i at bits [3i+2:3i]) wins. Tokens are checked only after the priority comparison. While top-level requesters have no tokens, lower-level requesters are not granted, even if they hold tokens.
- R5: In weighted mode each grant spends one token, and a requester with zero tokens is not granted. A requester whose weight (4 bits, requester i at bits [4i+3:4i]) is 0 gets no tokens at refill and is never granted after its reset token is spent.
- R6: With `period_i` = P (nonzero), budgets reload from the weights every P cycles, counted from reset or from the last refill. A value of 0 behaves as 1.
- R7: A refill also happens at an arbitration slot when weighted mode is on, some top-level requester has its `opt_dis_i` bit low, and no top-level requester holds tokens. The period count then restarts. With every such bit high, the arbiter waits for the timeout.
- R8: Saturating requesters of one level with weights 2, 3 and 4 receive grants in the ratio 2:3:4. A weight-15 requester against a weight-1 requester receives more than ten times as many grants.
- R9: With `wt_en_i` low, tokens are ignored and selection is by priority and round-robin alone.
- R10: Ties among eligible requesters at the top level are broken round-robin, starting at the index after the last one granted.
- R11: A weight changed in the middle of a period has no effect until the next refill.
- R12: The transmit (even index) and receive (odd index) requesters of a pair have separate weights, token budgets and early-refill bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2*NPAIR | Request per requester (even index transmit, odd index receive) |
| prio_i | input | 2*NPAIR*PRIO_W | Priority level per requester, larger wins |
| weight_i | input | 2*NPAIR*WGT_W | Weight per requester, tokens loaded at each refill |
| opt_dis_i | input | 2*NPAIR | Per-requester disable of early refill |
| wt_en_i | input | 1 | Global weighted-arbitration enable |
| period_i | input | PER_W | Refill period in clock cycles |
| done_i | input | 1 | Current burst finishes at this edge |
| gnt_o | output | 2*NPAIR | One-hot grant, held until done |

## Verification
The bench goes after the case where the top priority level has used up its tokens while a lower level still holds some. A design that checks tokens before priority would let the low level through there. It measures grant counts across refill periods. A weight applied immediately would show extra grants before the next refill, and a missing early refill would leave the bus idle until the timeout. It also checks the 2:3:4 and 15:1 splits, which come out wrong if a grant spends no token or a refill loses a budget. Finally, it checks the exact round-robin order and the hold of a grant while done is low, which expose a pointer that does not advance and a grant that moves mid-burst.

// File: rtl/wtok_arbiter.sv
module wtok_arbiter #(
  parameter int NPAIR      = 2,
  parameter int PRIO_W     = 3,
  parameter int WGT_W      = 4,
  parameter int PER_W      = 16,
  parameter int RST_TOKENS = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*NPAIR-1:0]          req_i,
  input  logic [2*NPAIR*PRIO_W-1:0]   prio_i,
  input  logic [2*NPAIR*WGT_W-1:0]    weight_i,
  input  logic [2*NPAIR-1:0]          opt_dis_i,
  input  logic                        wt_en_i,
  input  logic [PER_W-1:0]            period_i,
  input  logic                        done_i,
  output logic [2*NPAIR-1:0]          gnt_o
);
  localparam int N  = 2 * NPAIR;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][WGT_W-1:0] tok_q;
  logic [N-1:0]            gnt_q;
  logic [IW-1:0]           last_q;
  logic [PER_W-1:0]        cnt_q;

  logic [PRIO_W-1:0] top;
  logic [N-1:0]      at_top, cand, pick_oh;
  logic [IW-1:0]     pick;
  logic              found;

  wire slot   = ~|gnt_q | done_i;
  wire early  = slot & wt_en_i & ~|cand & |(at_top & ~opt_dis_i);
  wire tmo    = ({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, period_i};
  wire refill = tmo | early;

  assign gnt_o = gnt_q;

  // priority first, tokens second
  always_comb begin
    top = '0;
    for (int i = 0; i < N; i++)
      if (req_i[i] && prio_i[i*PRIO_W +: PRIO_W] > top)
        top = prio_i[i*PRIO_W +: PRIO_W];
    for (int i = 0; i < N; i++) begin
      at_top[i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] == top);
      cand[i]   = at_top[i] && (!wt_en_i || tok_q[i] != '0);
    end
  end

  // round-robin scan starting after the last grant
  always_comb begin
    int j;
    found = 1'b0;
    pick  = last_q;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last_q) + k) % N;
      if (!found && cand[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
    pick_oh = found ? (N'(1) << pick) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= IW'(N - 1);
      cnt_q  <= '0;
      for (int i = 0; i < N; i++) tok_q[i] <= WGT_W'(RST_TOKENS);
    end else begin
      cnt_q <= refill ? '0 : cnt_q + PER_W'(1);
      if (slot) begin
        gnt_q <= pick_oh;
        if (found) last_q <= pick;
      end
      for (int i = 0; i < N; i++) begin
        if (refill)
          tok_q[i] <= (slot && pick_oh[i] && wt_en_i && weight_i[i*WGT_W +: WGT_W] != '0)
                      ? weight_i[i*WGT_W +: WGT_W] - WGT_W'(1)
                      : weight_i[i*WGT_W +: WGT_W];
        else if (slot && pick_oh[i] && wt_en_i)
          tok_q[i] <= tok_q[i] - WGT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wtok_arbiter_chk.sv
module wtok_arbiter_chk #(
  parameter int N      = 4,
  parameter int PRIO_W = 3,
  parameter int WGT_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N-1:0]            req_i,
  input logic [N*PRIO_W-1:0]     prio_i,
  input logic                    wt_en_i,
  input logic                    done_i,
  input logic [N-1:0]            gnt_o,
  input logic [N-1:0][WGT_W-1:0] tok
);
  logic [N-1:0]            gnt_p, req_p, blk_p, blk;
  logic [N-1:0][WGT_W-1:0] tok_p;
  logic                    done_p, wt_p;

  always_comb
    for (int i = 0; i < N; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < N; j++)
        if (req_i[j] && prio_i[j*PRIO_W +: PRIO_W] > prio_i[i*PRIO_W +: PRIO_W]) blk[i] = 1'b1;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_p <= '0; req_p <= '0; blk_p <= '0; tok_p <= '0; done_p <= 1'b0; wt_p <= 1'b0;
    end else begin
      gnt_p <= gnt_o; req_p <= req_i; blk_p <= blk; tok_p <= tok; done_p <= done_i; wt_p <= wt_en_i;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_o && !done_i) |=> $stable(gnt_o));

  for (genvar i = 0; i < N; i++) begin : g_ch
    wire new_g = gnt_o[i] & (~gnt_p[i] | done_p);
    a_r2_req_seen: assert property (@(posedge clk) disable iff (!rst_n) new_g |-> req_p[i]);
    a_r4_prio: assert property (@(posedge clk) disable iff (!rst_n) new_g |-> !blk_p[i]);
    a_r5_token: assert property (@(posedge clk) disable iff (!rst_n)
      (new_g && wt_p) |-> (tok_p[i] != '0));
  end
endmodule

bind wtok_arbiter wtok_arbiter_chk #(.N(N), .PRIO_W(PRIO_W), .WGT_W(WGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i), .wt_en_i(wt_en_i),
  .done_i(done_i), .gnt_o(gnt_o), .tok(tok_q)
);

// File: tb/wtok_arbiter_tb.sv
`timescale 1ns/1ps
module wtok_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  req = '0, optd = '0, gnt;
  logic [11:0] prio = '0;
  logic [15:0] wgt = 16'h1111, per = 16'hFFFF;
  logic        en = 1'b0, done = 1'b1;
  int total = 0, fails = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  wtok_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .weight_i(wgt),
    .opt_dis_i(optd), .wt_en_i(en), .period_i(per), .done_i(done), .gnt_o(gnt)
  );

  typedef struct packed {
    logic             en;
    logic [3:0]       optd;
    logic [11:0]      prio;
    logic [15:0]      wgt;
    logic [3:0]       req;
    logic [15:0]      per;
    logic [15:0]      cyc;
    logic [3:0][15:0] expc;
    logic [7:0]       tol;
    logic [7:0]       tag;
  } row_t;

  localparam int NROW = 10;
  localparam row_t ROWS [NROW] = '{
    // R8: weights 2,3,4 share one level; R12: requesters 0 and 1 form one pair with separate budgets
    '{1'b1, 4'h0, 12'h000, 16'h0432, 4'h7, 16'hFFFF, 16'd200, {16'd0, 16'd79, 16'd60, 16'd41}, 8'd2, 8'd8},
    // R8: weight 15 against weight 1, more than tenfold
    '{1'b1, 4'h0, 12'h000, 16'h00F1, 4'h3, 16'hFFFF, 16'd170, {16'd0, 16'd0, 16'd149, 16'd11}, 8'd2, 8'd8},
    // R4: starved top level blocks a lower level holding tokens
    '{1'b1, 4'hF, 12'hA00, 16'h1111, 4'h9, 16'd20, 16'd100, {16'd5, 16'd0, 16'd0, 16'd0}, 8'd0, 8'd4},
    // R4: early refill serves only the top level
    '{1'b1, 4'h0, 12'hA00, 16'h1111, 4'h9, 16'hFFFF, 16'd100, {16'd50, 16'd0, 16'd0, 16'd0}, 8'd0, 8'd4},
    // R9: weighted mode off, priority alone
    '{1'b0, 4'hF, 12'hA00, 16'h1111, 4'h9, 16'd20, 16'd100, {16'd100, 16'd0, 16'd0, 16'd0}, 8'd0, 8'd9},
    // R5: weight 0 never granted after the reset token
    '{1'b1, 4'h0, 12'h000, 16'h1101, 4'h2, 16'hFFFF, 16'd50, {16'd0, 16'd0, 16'd1, 16'd0}, 8'd0, 8'd5},
    // R9: weight 0 ignored when weighted mode is off
    '{1'b0, 4'h0, 12'h000, 16'h1101, 4'h2, 16'hFFFF, 16'd50, {16'd0, 16'd0, 16'd50, 16'd0}, 8'd0, 8'd9},
    // R6: timeout refill every 10 cycles
    '{1'b1, 4'hF, 12'h000, 16'h1111, 4'h1, 16'd10, 16'd100, {16'd0, 16'd0, 16'd0, 16'd10}, 8'd0, 8'd6},
    // R7: early refill keeps the bus busy
    '{1'b1, 4'h0, 12'h000, 16'h1112, 4'h1, 16'hFFFF, 16'd30, {16'd0, 16'd0, 16'd0, 16'd20}, 8'd0, 8'd7},
    // R7: early refill disabled, waits for timeout
    '{1'b1, 4'hF, 12'h000, 16'h1112, 4'h1, 16'hFFFF, 16'd30, {16'd0, 16'd0, 16'd0, 16'd1}, 8'd0, 8'd7}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int idx_of(input logic [3:0] g);
    for (int i = 0; i < 4; i++) if (g == (4'b1 << i)) return i;
    return -1;
  endfunction

  initial begin
    #(8ns * 150000);
    if (!fin) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int c [4];
    int n;
    // R1: reset state
    req = 4'hF; en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(gnt == 4'h0, "R1 grant during reset", int'(gnt), 0);

    foreach (ROWS[r]) begin
      en = ROWS[r].en; optd = ROWS[r].optd; prio = ROWS[r].prio;
      wgt = ROWS[r].wgt; req = ROWS[r].req; per = ROWS[r].per; done = 1'b1;
      hold_reset();
      for (int ch = 0; ch < 4; ch++) c[ch] = 0;
      for (int k = 0; k < int'(ROWS[r].cyc); k++) begin
        @(negedge clk);
        for (int ch = 0; ch < 4; ch++) if (gnt[ch]) c[ch]++;
      end
      for (int ch = 0; ch < 4; ch++) begin
        int e, d;
        e = int'(ROWS[r].expc[ch]);
        d = c[ch] - e;
        if (d < 0) d = -d;
        chk(d <= int'(ROWS[r].tol),
            $sformatf("R%0d row %0d ch %0d grant count", ROWS[r].tag, r, ch), c[ch], e);
      end
      if (r == 1) chk(c[1] > 10 * c[0], "R8 fifteen-to-one ratio", c[1], 10 * c[0]);
    end

    // R10 and R1: round-robin from index 0, R2 back-to-back grants
    en = 1'b0; prio = '0; req = 4'hF; done = 1'b1; optd = 4'hF;
    hold_reset();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(idx_of(gnt) == (k % 4), "R10 round-robin order", idx_of(gnt), k % 4);
    end

    // R3: grant held while done is low
    req = 4'h3; done = 1'b0;
    hold_reset();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(gnt == 4'h1, "R3 grant held", int'(gnt), 1);
    end
    done = 1'b1;
    @(negedge clk);
    chk(gnt == 4'h2, "R3 next grant at done", int'(gnt), 2);
    done = 1'b0;
    @(negedge clk);
    chk(gnt == 4'h2, "R3 new grant held", int'(gnt), 2);

    // R11: weight written mid-period waits for the next refill
    en = 1'b1; optd = 4'hF; per = 16'd40; wgt = 16'h1111; req = 4'h1; done = 1'b1;
    hold_reset();
    @(negedge clk);
    chk(gnt == 4'h1, "R1 reset token grant", int'(gnt), 1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!gnt[0] && n < 100);
    wgt = 16'h1113;
    c[0] = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (gnt[0]) c[0]++;
    end
    chk(c[0] == 0, "R11 no grants before refill", c[0], 0);
    c[0] = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (gnt[0]) c[0]++;
    end
    chk(c[0] == 3, "R11 new weight after refill", c[0], 3);

    fin = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule